// File: doc/BRIEF.md
# Dual-Tagged Translation Lookaside Cache

This block is a small, fully associative cache of page translations. Each entry maps a linear page number to a physical frame. Each entry also holds read/write/execute rights and a memory type. An entry carries one of three tag kinds:

- an identifier tag only (a virtual-processor identifier);
- a root-pointer tag only (the root of the nested translation tables);
- both tags together.

The context inputs select which kinds a fill may create and which kinds a lookup may return:

- `nest_en` enables nested translation.
- `cur_id` is the current identifier.
- `cur_root` is the current root pointer.

A fill carries two sets of fields. The guest-level fields are present, reserved and rights. The nested-level fields are rights and memory type. The block accepts or rejects the fill in the same cycle. It reports the decision on `fill_acc`, and an accepted fill is written at the next clock edge. Lookups are combinational over the stored entries. Three invalidation requests clear entries in a single clock edge:

- by identifier;
- by root pointer;
- all entries.

The block has no sequencing state apart from a round-robin victim pointer. Its behaviour is one decision per cycle: filter the fill, find an in-place slot or the victim slot, apply any clears, and write.

Top module: `xlat_tag_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: With `nest_en`=0, an accepted fill creates an identifier-tagged entry. A later lookup with `nest_en`=0, the same `cur_id` and the same page hits. It returns the fill's frame, the guest rights `gst_perm` (bit 0 read, bit 1 write, bit 2 execute) and `gst_mtype`. A different identifier or page misses.
- R3: Two guest-level conditions reject a fill that uses guest information: `gst_present`=0, or `gst_rsvd`=1. A rejected fill drives `fill_acc` low and creates no entry.
- R4: With `nest_en`=0, `fill_root_only` is ignored and only identifier-tagged entries are created. Lookups with `nest_en`=1, guest-physical or linear, then miss on that page.
- R5: With `nest_en`=1 and `fill_root_only`=0, a fill creates a dual-tagged entry. A linear lookup (`lk_gphys`=0) with `nest_en`=1 hits it only when both `cur_id` and `cur_root` match. The returned rights are the bitwise AND of `gst_perm` and `nst_rwx`. The returned memory type is 0 when `gst_mtype` is 0, and otherwise `nst_mtype`.
- R6: The nested level rejects a dual-tagged or root-only fill in two cases. One is `nst_rwx`=3'b000. The other is write without read (`nst_rwx[1]`=1 and `nst_rwx[0]`=0). Any other non-zero value, such as execute-only, is accepted.
- R7: With `nest_en`=1 and `fill_root_only`=1, a fill creates a root-only entry. The guest fields are ignored for such a fill, and the rights and memory type come from `nst_rwx`/`nst_mtype`. Only guest-physical lookups (`lk_gphys`=1, `nest_en`=1) whose `cur_root` matches return this entry, whatever `cur_id` is.
- R8: Dual-tagged entries for the same page may coexist when they share an identifier but differ in root. They may also coexist when they share a root but differ in identifier. Each lookup returns the frame of its own pair, and at most one entry matches a lookup.
- R9: An identifier invalidation clears every identifier-only and dual-tagged entry whose identifier equals `inv_id`. Root-only entries and entries with other identifiers stay valid.
- R10: A root invalidation clears every root-only and dual-tagged entry whose root equals `inv_root`. Identifier-only entries and entries with other roots stay valid.
- R11: `inv_all` clears every entry in one clock edge.
- R12: A fill with the same kind, tags and page as a valid entry overwrites that entry in place. It does not allocate a slot and does not advance the victim pointer.
- R13: A fill that does not hit in place uses the round-robin victim slot, and the pointer then advances. After 16 such fills, the 17th evicts the first of the 16.
- R14: When an accepted fill and an invalidation fall in the same cycle, the invalidation clears its matches and the newly written entry remains valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nest_en | input | 1 | Nested translation enabled |
| cur_id | input | ID_W | Current identifier |
| cur_root | input | ROOT_W | Current nested root pointer |
| fill_req | input | 1 | Fill request |
| fill_root_only | input | 1 | Request a root-only entry (nested mode only) |
| fill_lpn | input | LPN_W | Page number to cache |
| fill_pfn | input | PFN_W | Frame number |
| gst_present | input | 1 | Guest entry present bit |
| gst_rsvd | input | 1 | Some guest reserved bit is set |
| gst_perm | input | 3 | Guest rights, bit 0 read, bit 1 write, bit 2 execute |
| gst_mtype | input | MT_W | Guest memory type |
| nst_rwx | input | 3 | Nested entry bits 2:0 (read, write, execute) |
| nst_mtype | input | MT_W | Nested memory type |
| fill_acc | output | 1 | Fill accepted this cycle |
| lk_lpn | input | LPN_W | Lookup page number |
| lk_gphys | input | 1 | Guest-physical lookup (nested mode only) |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame on hit, zero on miss |
| lk_perm | output | 3 | Rights on hit |
| lk_mtype | output | MT_W | Memory type on hit |
| inv_id_req | input | 1 | Invalidate by identifier |
| inv_id | input | ID_W | Identifier to invalidate |
| inv_root_req | input | 1 | Invalidate by root pointer |
| inv_root | input | ROOT_W | Root pointer to invalidate |
| inv_all | input | 1 | Invalidate all entries |

## Verification
The assertions assume the context and fill inputs are steady around the clock edge. They also assume that no two valid entries ever share kind, tags and page, which holds only when entries enter solely through the fill port. The single-hit property relies on that.

The rejection property applies only in cycles without an invalidation request. It assumes that a rejected fill is the only activity in such a cycle.

The bench drives every input at the falling edge and holds it for a full cycle. It returns all request lines to zero between operations. It only pairs a fill with an invalidation in the test written for that case.

// File: rtl/xtc_pkg.sv
package xtc_pkg;

    // bit 0: entry carries an identifier tag, bit 1: entry carries a root tag
    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_ID   = 2'b01,
        KIND_ROOT = 2'b10,
        KIND_DUAL = 2'b11
    } tag_kind_e;

    localparam int RIGHTS_W = 3;

    // nested entry usable: not all-zero, and not writable without readable
    function automatic logic nested_usable(input logic [RIGHTS_W-1:0] rwx);
        return (rwx != '0) && !(rwx[1] && !rwx[0]);
    endfunction

endpackage

// File: rtl/xtc_fill_filter.sv
module xtc_fill_filter
    import xtc_pkg::*;
#(
    parameter int MT_W = 3
) (
    input  logic                nest_en,
    input  logic                fill_req,
    input  logic                root_only,
    input  logic                gst_present,
    input  logic                gst_rsvd,
    input  logic [RIGHTS_W-1:0] gst_perm,
    input  logic [MT_W-1:0]     gst_mtype,
    input  logic [RIGHTS_W-1:0] nst_rwx,
    input  logic [MT_W-1:0]     nst_mtype,
    output logic                accept,
    output tag_kind_e           kind,
    output logic [RIGHTS_W-1:0] perm,
    output logic [MT_W-1:0]     mtype
);
    logic guest_ok;
    logic nest_ok;
    logic rule_ok;

    always_comb begin
        guest_ok = gst_present && !gst_rsvd;
        nest_ok  = nested_usable(nst_rwx);
        if (!nest_en) begin
            kind    = KIND_ID;
            rule_ok = guest_ok;
            perm    = gst_perm;
            mtype   = gst_mtype;
        end else if (root_only) begin
            kind    = KIND_ROOT;
            rule_ok = nest_ok;
            perm    = nst_rwx;
            mtype   = nst_mtype;
        end else begin
            kind    = KIND_DUAL;
            rule_ok = guest_ok && nest_ok;
            perm    = gst_perm & nst_rwx;
            mtype   = (gst_mtype == '0) ? '0 : nst_mtype;
        end
        accept = fill_req && rule_ok;
    end
endmodule

// File: rtl/xtc_victim_ptr.sv
module xtc_victim_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr <= '0;
        else if (step)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    p_ptr_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
endmodule

// File: rtl/xtc_entry_store.sv
module xtc_entry_store
    import xtc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int LPN_W   = 20,
    parameter int PFN_W   = 24,
    parameter int ID_W    = 12,
    parameter int ROOT_W  = 20,
    parameter int MT_W    = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    // write side
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    victim,
    input  tag_kind_e           wr_kind,
    input  logic [LPN_W-1:0]    wr_lpn,
    input  logic [PFN_W-1:0]    wr_pfn,
    input  logic [ID_W-1:0]     wr_id,
    input  logic [ROOT_W-1:0]   wr_root,
    input  logic [RIGHTS_W-1:0] wr_perm,
    input  logic [MT_W-1:0]     wr_mtype,
    output logic                inplace,
    output logic [IDX_W-1:0]    wr_idx,
    // invalidation
    input  logic                inv_id_req,
    input  logic [ID_W-1:0]     inv_id,
    input  logic                inv_root_req,
    input  logic [ROOT_W-1:0]   inv_root,
    input  logic                inv_all,
    // lookup
    input  tag_kind_e           lk_kind,
    input  logic [LPN_W-1:0]    lk_lpn,
    input  logic [ID_W-1:0]     lk_id,
    input  logic [ROOT_W-1:0]   lk_root,
    output logic                lk_hit,
    output logic [PFN_W-1:0]    lk_pfn,
    output logic [RIGHTS_W-1:0] lk_perm,
    output logic [MT_W-1:0]     lk_mtype,
    output logic [ENTRIES-1:0]  valid_vec
);
    tag_kind_e           kind_q  [ENTRIES];
    logic [LPN_W-1:0]    lpn_q   [ENTRIES];
    logic [PFN_W-1:0]    pfn_q   [ENTRIES];
    logic [ID_W-1:0]     id_q    [ENTRIES];
    logic [ROOT_W-1:0]   root_q  [ENTRIES];
    logic [RIGHTS_W-1:0] perm_q  [ENTRIES];
    logic [MT_W-1:0]     mtype_q [ENTRIES];

    logic [ENTRIES-1:0] fill_match;
    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] clear_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_comb begin
            fill_match[g] = valid_vec[g] && (kind_q[g] == wr_kind)
                         && (lpn_q[g] == wr_lpn)
                         && (!wr_kind[0] || (id_q[g] == wr_id))
                         && (!wr_kind[1] || (root_q[g] == wr_root));
            look_match[g] = valid_vec[g] && (kind_q[g] == lk_kind)
                         && (lpn_q[g] == lk_lpn)
                         && (!lk_kind[0] || (id_q[g] == lk_id))
                         && (!lk_kind[1] || (root_q[g] == lk_root));
            clear_vec[g]  = inv_all
                         || (inv_id_req && kind_q[g][0] && (id_q[g] == inv_id))
                         || (inv_root_req && kind_q[g][1] && (root_q[g] == inv_root));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 valid_vec[g] <= 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(g)))    valid_vec[g] <= 1'b1;
            else if (clear_vec[g])                      valid_vec[g] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                kind_q[g]  <= wr_kind;
                lpn_q[g]   <= wr_lpn;
                pfn_q[g]   <= wr_pfn;
                id_q[g]    <= wr_id;
                root_q[g]  <= wr_root;
                perm_q[g]  <= wr_perm;
                mtype_q[g] <= wr_mtype;
            end
        end
    end

    // slot selection: in-place match wins over the round-robin victim
    always_comb begin
        inplace = |fill_match;
        wr_idx  = victim;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i]) wr_idx = IDX_W'(i);
        end
    end

    // lookup result: OR over a one-hot match vector
    always_comb begin
        lk_hit   = |look_match;
        lk_pfn   = '0;
        lk_perm  = '0;
        lk_mtype = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_match[i]) begin
                lk_pfn   = lk_pfn   | pfn_q[i];
                lk_perm  = lk_perm  | perm_q[i];
                lk_mtype = lk_mtype | mtype_q[i];
            end
        end
    end

    p_single_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_match));

    p_single_fill_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_match));

    p_flush_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !wr_en) |=> (valid_vec == '0));
endmodule

// File: rtl/xlat_tag_cache.sv
module xlat_tag_cache
    import xtc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int LPN_W   = 20,
    parameter int PFN_W   = 24,
    parameter int ID_W    = 12,
    parameter int ROOT_W  = 20,
    parameter int MT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nest_en,
    input  logic [ID_W-1:0]   cur_id,
    input  logic [ROOT_W-1:0] cur_root,
    input  logic              fill_req,
    input  logic              fill_root_only,
    input  logic [LPN_W-1:0]  fill_lpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              gst_present,
    input  logic              gst_rsvd,
    input  logic [2:0]        gst_perm,
    input  logic [MT_W-1:0]   gst_mtype,
    input  logic [2:0]        nst_rwx,
    input  logic [MT_W-1:0]   nst_mtype,
    output logic              fill_acc,
    input  logic [LPN_W-1:0]  lk_lpn,
    input  logic              lk_gphys,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [2:0]        lk_perm,
    output logic [MT_W-1:0]   lk_mtype,
    input  logic              inv_id_req,
    input  logic [ID_W-1:0]   inv_id,
    input  logic              inv_root_req,
    input  logic [ROOT_W-1:0] inv_root,
    input  logic              inv_all
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tag_kind_e           fill_kind;
    tag_kind_e           lk_kind;
    logic [RIGHTS_W-1:0] fill_perm;
    logic [MT_W-1:0]     fill_mt;
    logic                inplace;
    logic [IDX_W-1:0]    victim;
    logic [IDX_W-1:0]    wr_idx;
    logic [ENTRIES-1:0]  valid_vec;

    always_comb begin
        if (!nest_en)      lk_kind = KIND_ID;
        else if (lk_gphys) lk_kind = KIND_ROOT;
        else               lk_kind = KIND_DUAL;
    end

    xtc_fill_filter #(.MT_W(MT_W)) u_filter (
        .nest_en    (nest_en),
        .fill_req   (fill_req),
        .root_only  (fill_root_only),
        .gst_present(gst_present),
        .gst_rsvd   (gst_rsvd),
        .gst_perm   (gst_perm),
        .gst_mtype  (gst_mtype),
        .nst_rwx    (nst_rwx),
        .nst_mtype  (nst_mtype),
        .accept     (fill_acc),
        .kind       (fill_kind),
        .perm       (fill_perm),
        .mtype      (fill_mt)
    );

    xtc_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
        .clk  (clk),
        .rst_n(rst_n),
        .step (fill_acc && !inplace),
        .ptr  (victim)
    );

    xtc_entry_store #(
        .ENTRIES(ENTRIES), .LPN_W(LPN_W), .PFN_W(PFN_W),
        .ID_W(ID_W), .ROOT_W(ROOT_W), .MT_W(MT_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (fill_acc),
        .victim      (victim),
        .wr_kind     (fill_kind),
        .wr_lpn      (fill_lpn),
        .wr_pfn      (fill_pfn),
        .wr_id       (cur_id),
        .wr_root     (cur_root),
        .wr_perm     (fill_perm),
        .wr_mtype    (fill_mt),
        .inplace     (inplace),
        .wr_idx      (wr_idx),
        .inv_id_req  (inv_id_req),
        .inv_id      (inv_id),
        .inv_root_req(inv_root_req),
        .inv_root    (inv_root),
        .inv_all     (inv_all),
        .lk_kind     (lk_kind),
        .lk_lpn      (lk_lpn),
        .lk_id       (cur_id),
        .lk_root     (cur_root),
        .lk_hit      (lk_hit),
        .lk_pfn      (lk_pfn),
        .lk_perm     (lk_perm),
        .lk_mtype    (lk_mtype),
        .valid_vec   (valid_vec)
    );

    p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_acc && !inv_id_req && !inv_root_req && !inv_all)
        |=> $stable(valid_vec));

    p_off_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_acc && !nest_en) |-> (fill_kind == KIND_ID));

    p_inplace_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_acc && inplace) |=> $stable(victim));

    p_fill_lands_r14: assert property (@(posedge clk) disable iff (!rst_n)
        fill_acc |=> valid_vec[$past(wr_idx)]);
endmodule

// File: tb/test_xlat_tag_cache.sv
module test_xlat_tag_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nest_en = 0;
    logic [11:0] cur_id = 0;
    logic [19:0] cur_root = 0;
    logic        fill_req = 0, fill_root_only = 0;
    logic [19:0] fill_lpn = 0;
    logic [23:0] fill_pfn = 0;
    logic        gst_present = 0, gst_rsvd = 0;
    logic [2:0]  gst_perm = 0, nst_rwx = 0, gst_mtype = 0, nst_mtype = 0;
    logic        fill_acc;
    logic [19:0] lk_lpn = 0;
    logic        lk_gphys = 0;
    logic        lk_hit;
    logic [23:0] lk_pfn;
    logic [2:0]  lk_perm, lk_mtype;
    logic        inv_id_req = 0, inv_root_req = 0, inv_all = 0;
    logic [11:0] inv_id = 0;
    logic [19:0] inv_root = 0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    xlat_tag_cache i_xlat_tag_cache (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic nest, input logic ronly, input int id, input int root,
                           input int lpn, input int pfn, input logic gp, input logic gr,
                           input int gperm, input int gmt, input int nrwx, input int nmt,
                           output logic acc);
        @(negedge clk);
        nest_en = nest; fill_root_only = ronly; cur_id = 12'(id); cur_root = 20'(root);
        fill_lpn = 20'(lpn); fill_pfn = 24'(pfn); gst_present = gp; gst_rsvd = gr;
        gst_perm = 3'(gperm); gst_mtype = 3'(gmt); nst_rwx = 3'(nrwx); nst_mtype = 3'(nmt);
        fill_req = 1'b1;
        #1 acc = fill_acc;
        @(negedge clk);
        fill_req = 1'b0; inv_all = 1'b0; inv_id_req = 1'b0; inv_root_req = 1'b0;
    endtask

    // simple helpers: guest-only fill and dual fill with full rights
    task automatic fill_id(input int id, input int lpn, input int pfn);
        logic a;
        do_fill(0, 0, id, 0, lpn, pfn, 1, 0, 3'b111, 6, 0, 0, a);
    endtask
    task automatic fill_dual(input int id, input int root, input int lpn, input int pfn);
        logic a;
        do_fill(1, 0, id, root, lpn, pfn, 1, 0, 3'b111, 6, 3'b111, 6, a);
    endtask
    task automatic fill_root(input int root, input int lpn, input int pfn);
        logic a;
        do_fill(1, 1, 0, root, lpn, pfn, 1, 0, 3'b111, 6, 3'b111, 6, a);
    endtask

    task automatic look(input logic nest, input logic gphys, input int id, input int root,
                        input int lpn);
        @(negedge clk);
        nest_en = nest; lk_gphys = gphys; cur_id = 12'(id); cur_root = 20'(root);
        lk_lpn = 20'(lpn);
        #1;
    endtask

    task automatic flush();
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
    endtask

    task automatic t_reset();
        look(0, 0, 5, 0, 'h100); chk("R1 hit after reset", lk_hit, 0);
        look(1, 0, 5, 1, 'h100); chk("R1 dual hit after reset", lk_hit, 0);
    endtask

    task automatic t_id_fill();
        logic a;
        do_fill(0, 0, 5, 0, 'h123, 'hABCDE, 1, 0, 3'b011, 6, 0, 0, a);
        chk("R2 accept", a, 1);
        look(0, 0, 5, 0, 'h123);
        chk("R2 hit", lk_hit, 1); chk("R2 pfn", lk_pfn, 'hABCDE);
        chk("R2 perm", lk_perm, 3'b011); chk("R2 mtype", lk_mtype, 6);
        look(0, 0, 6, 0, 'h123); chk("R2 other id miss", lk_hit, 0);
        look(0, 0, 5, 0, 'h124); chk("R2 other page miss", lk_hit, 0);
    endtask

    task automatic t_guest_reject();
        logic a;
        flush();
        do_fill(0, 0, 5, 0, 'h130, 1, 0, 0, 7, 6, 0, 0, a); chk("R3 not present reject", a, 0);
        look(0, 0, 5, 0, 'h130); chk("R3 not present miss", lk_hit, 0);
        do_fill(0, 0, 5, 0, 'h131, 1, 1, 1, 7, 6, 0, 0, a); chk("R3 reserved reject", a, 0);
        look(0, 0, 5, 0, 'h131); chk("R3 reserved miss", lk_hit, 0);
        do_fill(1, 0, 5, 9, 'h132, 1, 0, 0, 7, 6, 7, 6, a); chk("R3 dual guest reject", a, 0);
    endtask

    task automatic t_off_kinds();
        logic a;
        flush();
        do_fill(0, 1, 7, 'h55, 'h200, 'h22, 1, 0, 7, 6, 0, 0, a);
        chk("R4 accept in off mode", a, 1);
        look(0, 0, 7, 'h55, 'h200); chk("R4 id-kind hit", lk_hit, 1);
        look(1, 1, 7, 'h55, 'h200); chk("R4 no root entry", lk_hit, 0);
        look(1, 0, 7, 'h55, 'h200); chk("R4 no dual entry", lk_hit, 0);
    endtask

    task automatic t_dual();
        logic a;
        flush();
        do_fill(1, 0, 3, 'h77, 'h300, 'h333, 1, 0, 3'b111, 6, 3'b101, 4, a);
        chk("R5 accept", a, 1);
        do_fill(1, 0, 3, 'h77, 'h301, 'h334, 1, 0, 3'b011, 0, 3'b111, 6, a);
        look(1, 0, 3, 'h77, 'h300);
        chk("R5 hit", lk_hit, 1); chk("R5 pfn", lk_pfn, 'h333);
        chk("R5 perm and", lk_perm, 3'b101); chk("R5 mtype nested", lk_mtype, 4);
        look(1, 0, 3, 'h77, 'h301);
        chk("R5 perm and 2", lk_perm, 3'b011); chk("R5 mtype uncached", lk_mtype, 0);
        look(1, 0, 4, 'h77, 'h300); chk("R5 id mismatch", lk_hit, 0);
        look(1, 0, 3, 'h78, 'h300); chk("R5 root mismatch", lk_hit, 0);
        look(0, 0, 3, 'h77, 'h300); chk("R5 off-mode miss", lk_hit, 0);
    endtask

    task automatic t_nested_reject();
        logic a;
        flush();
        do_fill(1, 0, 3, 'h10, 'h310, 1, 1, 0, 7, 6, 3'b000, 6, a); chk("R6 zero reject", a, 0);
        do_fill(1, 0, 3, 'h10, 'h311, 1, 1, 0, 7, 6, 3'b010, 6, a); chk("R6 w-only reject", a, 0);
        do_fill(1, 1, 3, 'h10, 'h312, 1, 1, 0, 7, 6, 3'b110, 6, a); chk("R6 root wx reject", a, 0);
        look(1, 0, 3, 'h10, 'h310); chk("R6 miss", lk_hit, 0);
        look(1, 1, 3, 'h10, 'h312); chk("R6 root miss", lk_hit, 0);
        do_fill(1, 0, 3, 'h10, 'h313, 9, 1, 0, 7, 6, 3'b100, 6, a); chk("R6 x-only accept", a, 1);
        look(1, 0, 3, 'h10, 'h313); chk("R6 x-only perm", lk_perm, 3'b100);
    endtask

    task automatic t_root_only();
        logic a;
        flush();
        do_fill(1, 1, 9, 'h44, 'h400, 'h444, 0, 1, 0, 0, 3'b011, 5, a);
        chk("R7 guest ignored", a, 1);
        look(1, 1, 12, 'h44, 'h400);
        chk("R7 hit any id", lk_hit, 1); chk("R7 pfn", lk_pfn, 'h444);
        chk("R7 perm", lk_perm, 3'b011); chk("R7 mtype", lk_mtype, 5);
        look(1, 0, 9, 'h44, 'h400); chk("R7 linear miss", lk_hit, 0);
        look(1, 1, 9, 'h45, 'h400); chk("R7 root mismatch", lk_hit, 0);
    endtask

    task automatic t_coexist();
        flush();
        fill_dual(1, 'hA, 'h500, 'h11);
        fill_dual(1, 'hB, 'h500, 'h22);
        fill_dual(2, 'hA, 'h500, 'h33);
        look(1, 0, 1, 'hA, 'h500); chk("R8 id1 rootA", lk_pfn, 'h11);
        look(1, 0, 1, 'hB, 'h500); chk("R8 id1 rootB", lk_pfn, 'h22);
        look(1, 0, 2, 'hA, 'h500); chk("R8 id2 rootA", lk_pfn, 'h33);
    endtask

    task automatic t_inv_id();
        flush();
        fill_dual(1, 'hA, 'h600, 1);
        fill_id(1, 'h601, 2);
        fill_root('hA, 'h602, 3);
        fill_dual(2, 'hA, 'h603, 4);
        @(negedge clk); inv_id_req = 1; inv_id = 1;
        @(negedge clk); inv_id_req = 0;
        look(1, 0, 1, 'hA, 'h600); chk("R9 dual cleared", lk_hit, 0);
        look(0, 0, 1, 'hA, 'h601); chk("R9 id cleared", lk_hit, 0);
        look(1, 1, 1, 'hA, 'h602); chk("R9 root kept", lk_hit, 1);
        look(1, 0, 2, 'hA, 'h603); chk("R9 other id kept", lk_hit, 1);
    endtask

    task automatic t_inv_root();
        flush();
        fill_dual(1, 'hA, 'h700, 1);
        fill_root('hA, 'h701, 2);
        fill_id(1, 'h702, 3);
        fill_dual(1, 'hB, 'h703, 4);
        @(negedge clk); inv_root_req = 1; inv_root = 'hA;
        @(negedge clk); inv_root_req = 0;
        look(1, 0, 1, 'hA, 'h700); chk("R10 dual cleared", lk_hit, 0);
        look(1, 1, 1, 'hA, 'h701); chk("R10 root cleared", lk_hit, 0);
        look(0, 0, 1, 'hA, 'h702); chk("R10 id kept", lk_hit, 1);
        look(1, 0, 1, 'hB, 'h703); chk("R10 other root kept", lk_hit, 1);
    endtask

    task automatic t_inv_all();
        fill_id(4, 'h780, 1);
        fill_dual(4, 'hC, 'h781, 2);
        flush();
        look(0, 0, 4, 'hC, 'h780); chk("R11 id cleared", lk_hit, 0);
        look(1, 0, 4, 'hC, 'h781); chk("R11 dual cleared", lk_hit, 0);
    endtask

    task automatic t_inplace();
        flush();
        fill_id(8, 'h800, 1);
        fill_id(8, 'h800, 2);
        look(0, 0, 8, 0, 'h800); chk("R12 overwrite pfn", lk_pfn, 2);
        for (int k = 0; k < 15; k++) fill_id(8, 'h900 + k, k);
        look(0, 0, 8, 0, 'h800); chk("R12 no extra slot", lk_hit, 1);
        look(0, 0, 8, 0, 'h900); chk("R12 first filler kept", lk_hit, 1);
    endtask

    task automatic t_roundrobin();
        flush();
        for (int k = 0; k < 16; k++) fill_id(2, 'hA00 + k, k);
        fill_id(2, 'hB00, 'h77);
        look(0, 0, 2, 0, 'hA00); chk("R13 oldest evicted", lk_hit, 0);
        look(0, 0, 2, 0, 'hA01); chk("R13 second kept", lk_hit, 1);
        look(0, 0, 2, 0, 'hA0F); chk("R13 last kept", lk_hit, 1);
        look(0, 0, 2, 0, 'hB00); chk("R13 new hit", lk_pfn, 'h77);
    endtask

    task automatic t_fill_with_inv();
        flush();
        fill_id(6, 'hC01, 5);
        @(negedge clk);
        nest_en = 0; cur_id = 6; fill_root_only = 0; fill_lpn = 'hC00; fill_pfn = 'h66;
        gst_present = 1; gst_rsvd = 0; gst_perm = 7; gst_mtype = 6;
        fill_req = 1; inv_all = 1;
        @(negedge clk);
        fill_req = 0; inv_all = 0;
        look(0, 0, 6, 0, 'hC00); chk("R14 fill survives flush", lk_hit, 1);
        look(0, 0, 6, 0, 'hC01); chk("R14 old entry flushed", lk_hit, 0);
        @(negedge clk);
        fill_lpn = 'hC02; fill_req = 1; inv_id_req = 1; inv_id = 6;
        @(negedge clk);
        fill_req = 0; inv_id_req = 0;
        look(0, 0, 6, 0, 'hC02); chk("R14 fill survives id clear", lk_hit, 1);
        look(0, 0, 6, 0, 'hC00); chk("R14 id clear applied", lk_hit, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_id_fill();
        t_guest_reject();
        t_off_kinds();
        t_dual();
        t_nested_reject();
        t_root_only();
        t_coexist();
        t_inv_id();
        t_inv_root();
        t_inv_all();
        t_inplace();
        t_roundrobin();
        t_fill_with_inv();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule